// File: doc/BRIEF.md
# SD Card Clock Prescaler and Divisor Selector

This block sits behind the standard host clock-control register of an SD host controller. When software writes a clock-control value with the card clock enable set, the block works out the SD clock frequency being requested relative to a base frequency. It then searches, one step per clock cycle, for a power-of-two prescaler and a linear divisor of 1 to 16 whose product brings the base frequency down to that target. The chosen pair is written into a native clock register image in zero-based form.

Two request formats are supported, selected by the `newer` input. The older one is an 8-bit power-of-two divider field. The newer one is a 10-bit even divisor. The block works out divisions with shift-and-compare steps and a bit-serial quotient loop, not with a combinational divider. It holds `busy` while the search runs and pulses `done` when the new fields are in place.

Reads of the standard register are rebuilt from two sources. The frequency bits come from the last accepted write. The enable and stable flags come from the live state.

Top module: `sdclk_divsel`

## Requirements
- R1: After reset, `hw_clkreg` is 0, `busy` and `done` are low, and `rd_data` shows only bit 0 set, plus bit 1 if `clk_stable` is high and bit 2 if `newer` is high.
- R2: With `newer` low, the target is `base_hz` shifted right by the position, counted from 1, of the lowest set bit of `wr_data[15:8]`. When that field is zero, the shift is 0.
- R3: With `newer` high, the divisor is `{wr_data[7:6], wr_data[15:8]}`. A divisor of zero selects `base_hz` as the target. Any other value D selects floor(`base_hz` / (2·D)).
- R4: The prescaler P starts at 2. It doubles while target < floor(`base_hz` / (16·P)), and never passes 256.
- R5: With P fixed, the divisor N starts at 1. It increments while target < floor(`base_hz` / (P·N)), and never passes 16.
- R6: On completion, `hw_clkreg[15:8]` = P/2, `hw_clkreg[7:4]` = N−1, bit 0 = 1, and bits 2:1 = 0. With `newer` low, bit 3 (SD clock on) is also set. With `newer` high, bit 3 is kept as it was.
- R7: An accepted write with `wr_data[2]` = 1 raises `busy` in the next cycle. `done` is a single-cycle pulse with `busy` already low, and the new fields are present when `done` is high.
- R8: A write with `wr_data[2]` = 0 while `newer` is low clears `hw_clkreg[3]`, leaves the other fields untouched, and starts no search.
- R9: A write with `wr_data[2]` = 0 while `newer` is high leaves `hw_clkreg` entirely unchanged and starts no search.
- R10: `rd_data[15:6]` replays `wr_data[15:6]` of the last accepted write, and `rd_data[5:3]` are 0. Bit 0 is 1 and bit 1 follows `clk_stable`. Bit 2 is 1 when `newer` is high, otherwise `hw_clkreg[3]`.
- R11: A write issued while `busy` is high is ignored. It changes neither the replayed frequency bits nor the result of the running search, and it starts no search afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| newer | input | 1 | Request format: 0 = 8-bit power-of-two, 1 = 10-bit even divisor; held static |
| base_hz | input | FW | Base clock frequency; held static during a search |
| wr_en | input | 1 | Write strobe for the standard clock-control value |
| wr_data | input | 16 | Standard clock-control value being written |
| clk_stable | input | 1 | Internal-clock-stable flag from the present-state register |
| rd_data | output | 16 | Rebuilt standard clock-control value |
| hw_clkreg | output | 16 | Native clock register image (prescaler, divisor, enables) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the new fields are written |

## Verification
The search is driven with both request formats. Directed cases include a divider field with several bits set, which separates the lowest-set-bit rule from a highest-bit rule. They also cover zero divisors in both formats, a request using only the high divisor bits, the largest 10-bit divisor, a zero base and a full-scale base. Random writes with random bases then compare the fields against a reference search that uses true integer division. This catches an off-by-one in either compare loop or in the zero-based encoding. Disable writes in both formats are followed by register checks that tell the bit-3 clear apart from a full no-op. A write that lands during a long quotient phase shows whether the block drops it.

// File: rtl/sdclk_divsel.sv
module sdclk_divsel #(
  parameter int FW      = 32,
  parameter int PSH_MAX = 8,
  parameter int DIV_MAX = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          newer,
  input  logic [FW-1:0] base_hz,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          clk_stable,
  output logic [15:0]   rd_data,
  output logic [15:0]   hw_clkreg,
  output logic          busy,
  output logic          done
);

  localparam int AW = FW + PSH_MAX + 5;
  localparam int PW = $clog2(PSH_MAX + 1);
  localparam int DW = $clog2(DIV_MAX + 1);
  localparam int CW = $clog2(FW + 1);

  typedef enum logic [1:0] {S_IDLE, S_QUO, S_PRE, S_LIN} st_t;

  st_t           st;
  logic [FW-1:0] freq, dvd, quo;
  logic [10:0]   rem, den;
  logic [CW-1:0] cnt;
  logic [PW-1:0] psh;
  logic [DW-1:0] dv;
  logic [AW-1:0] acc;
  logic [9:0]    fbits;
  logic [7:0]    pre_f;
  logic [3:0]    div_f;
  logic          en_b, sd_b, done_q;

  logic [7:0]    d8;
  logic [9:0]    d10;
  logic [3:0]    lsb_pos;
  logic [FW-1:0] old_tgt;
  logic [AW-1:0] f1_ext, base_ext, pre_probe, step;
  logic          pre_go, lin_go;
  logic [11:0]   rem_sh, rem_nx;
  logic          sub_ok;
  logic [FW-1:0] quo_nx;
  wire           unused_bits = ^{wr_data[5:3], wr_data[1:0]};

  assign d8  = wr_data[15:8];
  assign d10 = {wr_data[7:6], wr_data[15:8]};

  always_comb begin
    lsb_pos = '0;
    for (int i = 7; i >= 0; i--)
      if (d8[i]) lsb_pos = 4'(i + 1);
  end

  assign old_tgt   = base_hz >> lsb_pos;
  assign f1_ext    = AW'(freq) + AW'(1);
  assign base_ext  = AW'(base_hz);
  assign pre_probe = f1_ext << (32'(psh) + 4);
  assign step      = f1_ext << psh;
  assign pre_go    = (psh < PW'(PSH_MAX)) && (pre_probe <= base_ext);
  assign lin_go    = (dv < DW'(DIV_MAX)) && (acc <= base_ext);

  assign rem_sh = {rem, dvd[FW-1]};
  assign sub_ok = rem_sh >= {1'b0, den};
  assign rem_nx = sub_ok ? rem_sh - {1'b0, den} : rem_sh;
  assign quo_nx = {quo[FW-2:0], sub_ok};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; freq <= '0; dvd <= '0; quo <= '0; rem <= '0; den <= '0;
      cnt <= '0; psh <= PW'(1); dv <= DW'(1); acc <= '0; fbits <= '0;
      pre_f <= '0; div_f <= '0; en_b <= 1'b0; sd_b <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (wr_en) begin
          fbits <= wr_data[15:6];
          if (!wr_data[2]) begin
            if (!newer) sd_b <= 1'b0;
          end else if (!newer) begin
            freq <= old_tgt; psh <= PW'(1); st <= S_PRE;
          end else if (d10 == '0) begin
            freq <= base_hz; psh <= PW'(1); st <= S_PRE;
          end else begin
            den <= {d10, 1'b0}; dvd <= base_hz; rem <= '0; quo <= '0;
            cnt <= '0; st <= S_QUO;
          end
        end
        S_QUO: begin
          dvd <= dvd << 1;
          rem <= rem_nx[10:0];
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(FW - 1)) begin
            freq <= quo_nx; psh <= PW'(1); st <= S_PRE;
          end
        end
        S_PRE: begin
          if (pre_go) psh <= psh + 1'b1;
          else begin
            dv <= DW'(1); acc <= step; st <= S_LIN;
          end
        end
        S_LIN: begin
          if (lin_go) begin
            dv <= dv + 1'b1; acc <= acc + step;
          end else begin
            pre_f  <= 8'd1 << (psh - 1'b1);
            div_f  <= 4'(dv - 1'b1);
            en_b   <= 1'b1;
            if (!newer) sd_b <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hw_clkreg = {pre_f, div_f, sd_b, 2'b00, en_b};
  assign rd_data   = {fbits, 3'b000, newer ? 1'b1 : sd_b, clk_stable, 1'b1};
  assign busy      = (st != S_IDLE);
  assign done      = done_q;

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_fields_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hw_clkreg[0] && $onehot0(hw_clkreg[15:8]) && hw_clkreg[15:8] != 8'd0));
  a_r11_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(rd_data[15:6]));
  a_r9_newer_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !wr_data[2] && newer) |=> ($stable(hw_clkreg) && !busy));
  a_r8_older_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !wr_data[2] && !newer) |=> (!hw_clkreg[3] && !busy));
  a_r4_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE) |-> (psh >= PW'(1) && psh <= PW'(PSH_MAX)));
  a_r5_divisor_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LIN) |-> (dv >= DW'(1) && dv <= DW'(DIV_MAX)));

endmodule

// File: tb/sdclk_divsel_bench.sv
`timescale 1ns/1ps
module sdclk_divsel_bench;
  logic        clk = 1'b0, rst_n = 1'b0, newer = 1'b0, wr_en = 1'b0, clk_stable = 1'b0;
  logic [31:0] base_hz = 32'd200_000_000;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data, hw_clkreg;
  logic        busy, done;
  int total = 0, bad = 0;
  logic [15:0] mreg = '0;
  logic [9:0]  mfb = '0;

  sdclk_divsel u_sdclk_divsel (
    .clk(clk), .rst_n(rst_n), .newer(newer), .base_hz(base_hz), .wr_en(wr_en),
    .wr_data(wr_data), .clk_stable(clk_stable), .rd_data(rd_data),
    .hw_clkreg(hw_clkreg), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] tgt(input logic nw, input logic [31:0] b, input logic [15:0] w);
    int k = 0;
    longint unsigned d;
    if (!nw) begin
      for (int i = 7; i >= 0; i--) if (w[8+i]) k = i + 1;
      return b >> k;
    end
    d = {w[7:6], w[15:8]};
    if (d == 0) return b;
    return 32'(longint'(b) / (2 * d));
  endfunction

  function automatic logic [15:0] fields(input logic [31:0] b, input logic [31:0] f);
    longint unsigned p = 2, n = 1, bb = b, ff = f;
    while (p < 256 && ff < bb / (p * 16)) p = p * 2;
    while (n < 16 && ff < bb / (p * n)) n++;
    return {8'(p / 2), 4'(n - 1), 4'b0000};
  endfunction

  function automatic logic [15:0] exp_rd();
    return {mfb, 3'b000, newer ? 1'b1 : mreg[3], clk_stable, 1'b1};
  endfunction

  task automatic wr(input logic nw, input logic [31:0] b, input logic [15:0] w);
    logic [15:0] fl;
    int n = 0;
    @(negedge clk);
    newer = nw; base_hz = b; wr_data = w; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    mfb = w[15:6];
    if (w[2]) begin
      check("R7 busy after enabled write", busy, 1);
      while (!done && n < 200) begin @(negedge clk); n++; end
      check("R7 done pulse seen", done, 1);
      check("R7 busy low with done", busy, 0);
      fl = fields(b, tgt(nw, b, w));
      mreg[15:4] = fl[15:4];
      mreg[0] = 1'b1;
      if (!nw) mreg[3] = 1'b1;
      check(nw ? "R3 R4 prescale field (newer)" : "R2 R4 prescale field (older)",
            hw_clkreg[15:8], mreg[15:8]);
      check(nw ? "R3 R5 divisor field (newer)" : "R2 R5 divisor field (older)",
            hw_clkreg[7:4], mreg[7:4]);
      check("R6 full register image", hw_clkreg, mreg);
      @(negedge clk);
      check("R7 done lasts one cycle", done, 0);
    end else begin
      if (!nw) mreg[3] = 1'b0;
      check(nw ? "R9 newer disable keeps register" : "R8 older disable clears bit3",
            hw_clkreg, mreg);
      check(nw ? "R9 no search" : "R8 no search", busy, 0);
    end
    check("R10 readback", rd_data, exp_rd());
  endtask

  initial begin
    #900_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] fl;
    int n;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset register", hw_clkreg, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);
    check("R1 reset readback older", rd_data, 16'h0001);
    newer = 1'b1; clk_stable = 1'b1;
    #1;
    check("R1 reset readback newer", rd_data, 16'h0007);
    clk_stable = 1'b0;

    wr(0, 32'd200_000_000, 16'h0104);
    wr(0, 32'd200_000_000, 16'h8004);
    wr(0, 32'd200_000_000, 16'h0004);
    wr(0, 32'd200_000_000, 16'h0C04);
    wr(0, 32'd100, 16'h8004);
    wr(0, 32'd0, 16'h2004);
    wr(0, 32'd52_000_000, 16'h0100);
    clk_stable = 1'b1;
    wr(1, 32'd200_000_000, 16'h0004);
    wr(1, 32'd200_000_000, 16'h0104);
    wr(1, 32'd200_000_000, 16'h00C4);
    wr(1, 32'd200_000_000, 16'hFFC4);
    wr(1, 32'hFFFF_FFFF, 16'h0104);
    wr(1, 32'd1000, 16'hFFC4);
    wr(1, 32'd200_000_000, 16'h7F00);

    // R11: write issued during a long quotient phase
    @(negedge clk);
    newer = 1'b1; base_hz = 32'd198_000_000; wr_data = 16'h0504; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    mfb = 10'(16'h0504 >> 6);
    fl = fields(32'd198_000_000, tgt(1, 32'd198_000_000, 16'h0504));
    repeat (3) @(negedge clk);
    wr_data = 16'h01C4; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 replay bits unchanged by busy write", rd_data[15:6], mfb);
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    mreg[15:4] = fl[15:4]; mreg[0] = 1'b1;
    check("R11 result from first write", hw_clkreg, mreg);
    repeat (3) @(negedge clk);
    check("R11 no search after ignored write", busy, 0);
    check("R11 readback after ignored write", rd_data, exp_rd());

    for (int i = 0; i < 60; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      w[2] = ($urandom % 5) != 0;
      clk_stable = 1'($urandom);
      wr(1'($urandom), $urandom, w);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule